// File: doc/BRIEF.md
# Multi-Channel Management Controller KCS Register Block

This block gives a management controller a set of independent keyboard-controller-style mailbox channels. Each channel has an input byte written by the host, an output byte read by the host, a status byte with input-full, output-full and command/data flags, a control byte holding two interrupt enables, and two host-interrupt registers that keep fixed values. The controller reaches every channel over one byte-wide register bus; the host reaches one channel at a time through a byte port with data-write, command-write and read strobes.

The flags in the status byte move only as a side effect of buffer accesses by either side. All channels share one registered, level-sensitive interrupt line toward the controller: host activity on an enabled channel raises it, and the controller servicing that channel's buffer lowers it.

Top module: `kcs_regfile`

## Requirements
- R1: After reset every channel reads status 0x00, control 0xC0, interrupt control 0x41 and interrupt enable 0x00, and `irq` is 0.
- R2: Channel c occupies bus addresses 0x0C + 0x12*c up to 0x0C + 0x12*c + 0x10 with a stride of 2; register index i sits at base + 2*i, with 0 status, 1 data-out, 2 data-in, 3 data-out alias A, 4 data-out alias B, 5 data-in alias, 6 control, 7 interrupt control, 8 interrupt enable. Odd addresses and addresses below 0x0C or at 0x42 and above read 0 and writes to them change nothing.
- R3: A controller read of data-in (index 2 or 5) returns the input byte and clears IBF (status bit 1); when control bit 0 is set it lowers the interrupt.
- R4: A host data or command write loads the input byte and sets IBF; a command write sets status bit 3 and a data write clears it; when control bit 0 is set it raises the interrupt.
- R5: A controller write to index 1, 3 or 4 loads the output byte and sets OBF (status bit 0); when control bit 1 is set it lowers the interrupt. Reads of those indices return 0 and writes to index 2 or 5 are ignored.
- R6: `host_rdata` shows the output byte of the channel on `host_chan` in the same cycle; a host read strobe clears OBF and, when control bit 1 is set, raises the interrupt.
- R7: A controller write to status updates only bits 7:4 and bit 2; bits 3, 1 and 0 keep their values.
- R8: The control register stores the full written byte and reads it back; writes to interrupt control and interrupt enable have no effect.
- R9: `irq` changes one cycle after an event: set after any raise, cleared after any lower, and set when a raise and a lower occur in the same cycle.
- R10: `bus_rdata` carries the read value in the cycle after a read select and is 0 in every other cycle.
- R11: An access to one channel changes no state of any other channel, and host writes on a channel whose enables are clear leave `irq` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Controller register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W (8) | Controller byte address |
| bus_wdata | input | 8 | Controller write byte |
| bus_rdata | output | 8 | Read byte, valid the cycle after select |
| host_chan | input | CH_W (2) | Channel addressed by the host port |
| host_wr_data | input | 1 | Host data write strobe |
| host_wr_cmd | input | 1 | Host command write strobe |
| host_rd | input | 1 | Host read strobe (clears OBF) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Output byte of the addressed channel |
| irq | output | 1 | Shared level interrupt to the controller |

## Verification
Controller reads are due one cycle after the select, so the scoreboard queues each expected byte when the driver issues the read and the monitor pops it on the falling edge after the next rising edge. Flag changes and the interrupt level settle at the first rising edge after a strobe and are checked on the following falling edge, before any further stimulus. Host read data is combinational and is compared while the read strobe is still held.

// File: rtl/kcs_pkg.sv
// Shared register indices, status bit positions and reset constants for the
// KCS register block. Assumes byte-wide registers.
package kcs_pkg;

    localparam int REG_CNT = 9;
    localparam int REG_W   = 4;

    // Register order inside a channel; the index times the stride is the offset.
    typedef enum logic [REG_W-1:0] {
        RG_STAT    = 4'd0,
        RG_DOUT    = 4'd1,
        RG_DIN     = 4'd2,
        RG_DOUT_A  = 4'd3,
        RG_DOUT_B  = 4'd4,
        RG_DIN_A   = 4'd5,
        RG_CTRL    = 4'd6,
        RG_ICTL    = 4'd7,
        RG_IEN     = 4'd8
    } kcs_reg_e;

    localparam int ST_CMD = 3;
    localparam int ST_IBF = 1;
    localparam int ST_OBF = 0;

    // Status bits the controller may write directly.
    localparam logic [7:0] STAT_SW_MASK = 8'hF4;

    localparam logic [7:0] CTRL_RST = 8'hC0;
    localparam logic [7:0] ICTL_VAL = 8'h41;
    localparam logic [7:0] IEN_VAL  = 8'h00;

    localparam int CTRL_IBF_IE = 0;
    localparam int CTRL_OBE_IE = 1;

endpackage

// File: rtl/kcs_addr_dec.sv
// Address decoder: maps a controller byte address onto a channel number and a
// register index. Assumes channels are laid out back to back from FIRST_BASE,
// each REG_CNT registers spaced STRIDE bytes apart. Purely combinational.
module kcs_addr_dec
    import kcs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_CH     = 3,
    parameter int FIRST_BASE = 12,
    parameter int STRIDE     = 2,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_o,
    output logic [CH_W-1:0]   ch_o,
    output kcs_reg_e          reg_o
);

    localparam int SPAN = REG_CNT * STRIDE;

    logic [NUM_CH-1:0] in_rng;
    logic [NUM_CH-1:0] aligned;
    logic [ADDR_W-1:0] off_c [NUM_CH];
    logic [REG_W-1:0]  idx_c [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_win
        localparam int BASE = FIRST_BASE + c * SPAN;
        // Range test and offset for one channel window.
        assign in_rng[c]  = (int'(addr_i) >= BASE) && (int'(addr_i) < BASE + SPAN);
        assign off_c[c]   = addr_i - ADDR_W'(BASE);
        assign aligned[c] = (off_c[c] % ADDR_W'(STRIDE)) == '0;
        assign idx_c[c]   = REG_W'(off_c[c] / ADDR_W'(STRIDE));
    end

    // Pick the single matching window, if any.
    always_comb begin
        hit_o = 1'b0;
        ch_o  = '0;
        reg_o = RG_STAT;
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_rng[c] && aligned[c]) begin
                hit_o = 1'b1;
                ch_o  = CH_W'(c);
                reg_o = kcs_reg_e'(idx_c[c]);
            end
        end
    end

endmodule

// File: rtl/kcs_chan.sv
// One KCS channel: input/output bytes, status flags, control register and
// interrupt events. Assumes at most one controller access per cycle; a host
// event on a flag wins over a same-cycle controller event on that flag.
module kcs_chan
    import kcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_en,
    input  logic       acc_we,
    input  kcs_reg_e   acc_rg,
    input  logic [7:0] acc_wdata,
    input  logic       hst_en,
    input  logic       hst_wr_data,
    input  logic       hst_wr_cmd,
    input  logic       hst_rd,
    input  logic [7:0] hst_wdata,
    output logic [7:0] rd_val,
    output logic [7:0] out_byte,
    output logic       irq_up,
    output logic       irq_dn
);

    logic [7:0] in_byte;
    logic [7:0] sw_bits;
    logic [7:0] ctrl;
    logic       cmd_f, ibf, obf;

    logic ctl_rd_din, ctl_wr_dout, ctl_wr_stat, ctl_wr_ctrl;
    logic h_wr, h_rd;

    // Decode controller and host events for this channel.
    always_comb begin
        ctl_rd_din  = acc_en && !acc_we && (acc_rg == RG_DIN || acc_rg == RG_DIN_A);
        ctl_wr_dout = acc_en && acc_we &&
                      (acc_rg == RG_DOUT || acc_rg == RG_DOUT_A || acc_rg == RG_DOUT_B);
        ctl_wr_stat = acc_en && acc_we && (acc_rg == RG_STAT);
        ctl_wr_ctrl = acc_en && acc_we && (acc_rg == RG_CTRL);
        h_wr        = hst_en && (hst_wr_data || hst_wr_cmd);
        h_rd        = hst_en && hst_rd;
    end

    // Data bytes, writable status bits and control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_byte  <= 8'h00;
            out_byte <= 8'h00;
            sw_bits  <= 8'h00;
            ctrl     <= CTRL_RST;
        end else begin
            if (h_wr)        in_byte  <= hst_wdata;
            if (ctl_wr_dout) out_byte <= acc_wdata;
            if (ctl_wr_stat) sw_bits  <= acc_wdata & STAT_SW_MASK;
            if (ctl_wr_ctrl) ctrl     <= acc_wdata;
        end
    end

    // Hardware-owned flags: command/data, input full, output full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_f <= 1'b0;
            ibf   <= 1'b0;
            obf   <= 1'b0;
        end else begin
            if (h_wr)            cmd_f <= hst_wr_cmd;
            if (h_wr)            ibf   <= 1'b1;
            else if (ctl_rd_din) ibf   <= 1'b0;
            if (h_rd)             obf  <= 1'b0;
            else if (ctl_wr_dout) obf  <= 1'b1;
        end
    end

    // Register read mux for the controller bus.
    always_comb begin
        case (acc_rg)
            RG_STAT:          rd_val = sw_bits | {4'b0, cmd_f, 1'b0, ibf, obf};
            RG_DIN, RG_DIN_A: rd_val = in_byte;
            RG_CTRL:          rd_val = ctrl;
            RG_ICTL:          rd_val = ICTL_VAL;
            RG_IEN:           rd_val = IEN_VAL;
            default:          rd_val = 8'h00;
        endcase
    end

    // Interrupt raise and lower events gated by the enables.
    always_comb begin
        irq_up = (h_wr && ctrl[CTRL_IBF_IE]) || (h_rd && ctrl[CTRL_OBE_IE]);
        irq_dn = (ctl_rd_din && ctrl[CTRL_IBF_IE]) || (ctl_wr_dout && ctrl[CTRL_OBE_IE]);
    end

    a_r4_host_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> (ibf && cmd_f == $past(hst_wr_cmd) && in_byte == $past(hst_wdata)));

    a_r3_din_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rd_din && !h_wr) |=> !ibf);

    a_r5_dout_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_dout && !h_rd) |=> (obf && out_byte == $past(acc_wdata)));

    a_r6_host_read_empties: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> !obf);

    a_r7_status_write_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr_stat && !h_wr && !h_rd) |=> ($stable(ibf) && $stable(obf) && $stable(cmd_f)));

endmodule

// File: rtl/kcs_irq_merge.sv
// Shared interrupt level: ORs the per-channel raise and lower events into one
// registered line. Assumes events are single-cycle pulses; raise has priority.
module kcs_irq_merge #(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] up_i,
    input  logic [NUM_CH-1:0] dn_i,
    output logic              irq_o
);

    // Sticky level: set on any raise, else cleared on any lower.
    always_ff @(posedge clk) begin
        if (!rst_n)      irq_o <= 1'b0;
        else if (|up_i)  irq_o <= 1'b1;
        else if (|dn_i)  irq_o <= 1'b0;
    end

    a_r9_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|up_i) |=> irq_o);

    a_r9_lower_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dn_i) && !(|up_i)) |=> !irq_o);

    a_r9_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|dn_i) && !(|up_i)) |=> $stable(irq_o));

endmodule

// File: rtl/kcs_regfile.sv
// Top of the KCS register block: decodes the controller bus, instantiates one
// channel per NUM_CH, registers bus read data and merges interrupts.
// Assumes one controller access and one host access per cycle at most.
module kcs_regfile
    import kcs_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int ADDR_W     = 8,
    parameter int FIRST_BASE = 12,
    parameter int STRIDE     = 2,
    localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic [CH_W-1:0]   host_chan,
    input  logic              host_wr_data,
    input  logic              host_wr_cmd,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq
);

    logic             dec_hit;
    logic [CH_W-1:0]  dec_ch;
    kcs_reg_e         dec_reg;
    logic [7:0]       ch_rd   [NUM_CH];
    logic [7:0]       ch_out  [NUM_CH];
    logic [NUM_CH-1:0] ch_up, ch_dn;

    kcs_addr_dec #(
        .ADDR_W     (ADDR_W),
        .NUM_CH     (NUM_CH),
        .FIRST_BASE (FIRST_BASE),
        .STRIDE     (STRIDE)
    ) u_dec (
        .addr_i (bus_addr),
        .hit_o  (dec_hit),
        .ch_o   (dec_ch),
        .reg_o  (dec_reg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        kcs_chan u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .acc_en      (bus_sel && dec_hit && (dec_ch == CH_W'(c))),
            .acc_we      (bus_we),
            .acc_rg      (dec_reg),
            .acc_wdata   (bus_wdata),
            .hst_en      (host_chan == CH_W'(c)),
            .hst_wr_data (host_wr_data),
            .hst_wr_cmd  (host_wr_cmd),
            .hst_rd      (host_rd),
            .hst_wdata   (host_wdata),
            .rd_val      (ch_rd[c]),
            .out_byte    (ch_out[c]),
            .irq_up      (ch_up[c]),
            .irq_dn      (ch_dn[c])
        );
    end

    // Host sees the addressed channel's output byte without delay.
    always_comb begin
        host_rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++)
            if (host_chan == CH_W'(c)) host_rdata = ch_out[c];
    end

    // Bus read data register: value of a decoded read, otherwise zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_sel && !bus_we && dec_hit)
            bus_rdata <= ch_rd[dec_ch];
        else
            bus_rdata <= 8'h00;
    end

    kcs_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .up_i  (ch_up),
        .dn_i  (ch_dn),
        .irq_o (irq)
    );

    a_r2_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !dec_hit) |=> (bus_rdata == 8'h00));

    a_r10_idle_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> (bus_rdata == 8'h00));

    a_r2_odd_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr[0] |-> !dec_hit);

endmodule

// File: tb/kcs_regfile_bench.sv
`timescale 1ns/1ps
module kcs_regfile_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [1:0] host_chan = 2'd0;
    logic       host_wr_data = 1'b0, host_wr_cmd = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;
    logic pend = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    kcs_regfile u_kcs_regfile (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .host_chan(host_chan), .host_wr_data(host_wr_data),
        .host_wr_cmd(host_wr_cmd), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ra(input int ch, input int idx);
        return 8'(12 + 18 * ch + 2 * idx);
    endfunction

    // Monitor: a read issued last cycle is compared against the queue head.
    always @(posedge clk) pend <= bus_sel && !bus_we && rst_n;
    always @(negedge clk) begin
        if (pend) begin
            if (exp_q.size() == 0) chk(bus_rdata, 8'hxx, "R10 unexpected read");
            else chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic host_wr(input int ch, input logic [7:0] d, input logic is_cmd);
        @(negedge clk);
        host_chan = 2'(ch); host_wdata = d;
        host_wr_cmd = is_cmd; host_wr_data = !is_cmd;
        @(negedge clk);
        host_wr_cmd = 1'b0; host_wr_data = 1'b0;
    endtask

    task automatic host_rd_chk(input int ch, input logic [7:0] e, input string tag);
        @(negedge clk);
        host_chan = 2'(ch); host_rd = 1'b1;
        #1 chk(host_rdata, e, tag);
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({7'b0, irq}, 8'h00, "R1 irq in reset");
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) begin
            bus_rd(ra(c, 0), 8'h00, "R1 status reset");
            bus_rd(ra(c, 6), 8'hC0, "R1 control reset");
            bus_rd(ra(c, 7), 8'h41, "R1 int control reset");
            bus_rd(ra(c, 8), 8'h00, "R1 int enable reset");
        end
        // R8: control stores, fixed registers ignore writes
        bus_wr(ra(0, 6), 8'h03);
        bus_rd(ra(0, 6), 8'h03, "R8 control readback");
        bus_wr(ra(0, 7), 8'hFF);
        bus_wr(ra(0, 8), 8'hFF);
        bus_rd(ra(0, 7), 8'h41, "R8 int control write ignored");
        bus_rd(ra(0, 8), 8'h00, "R8 int enable write ignored");
        // R4 / R3: data write then read
        host_wr(0, 8'h5A, 1'b0);
        chk({7'b0, irq}, 8'h01, "R4 irq raised by host write");
        bus_rd(ra(0, 0), 8'h02, "R4 IBF set data flag clear");
        bus_rd(ra(0, 2), 8'h5A, "R3 data-in byte");
        chk({7'b0, irq}, 8'h00, "R3 irq lowered by data-in read");
        bus_rd(ra(0, 0), 8'h00, "R3 IBF cleared");
        host_wr(0, 8'hA5, 1'b1);
        bus_rd(ra(0, 0), 8'h0A, "R4 command flag set");
        bus_rd(ra(0, 5), 8'hA5, "R3 data-in alias byte");
        bus_rd(ra(0, 0), 8'h08, "R3 IBF cleared via alias");
        // R5 / R6: output path
        bus_wr(ra(0, 1), 8'h33);
        bus_rd(ra(0, 0), 8'h09, "R5 OBF set");
        bus_rd(ra(0, 1), 8'h00, "R5 data-out reads zero");
        host_rd_chk(0, 8'h33, "R6 host read byte");
        chk({7'b0, irq}, 8'h01, "R6 irq raised by host read");
        bus_rd(ra(0, 0), 8'h08, "R6 OBF cleared");
        bus_wr(ra(0, 4), 8'h44);
        chk({7'b0, irq}, 8'h00, "R5 irq lowered by data-out alias write");
        host_rd_chk(0, 8'h44, "R5 alias B byte");
        bus_wr(ra(0, 3), 8'h77);
        host_rd_chk(0, 8'h77, "R5 alias A byte");
        chk({7'b0, irq}, 8'h01, "R6 irq after second host read");
        host_wr(0, 8'h11, 1'b0);
        bus_wr(ra(0, 2), 8'hEE);
        bus_rd(ra(0, 0), 8'h02, "R5 status after data write");
        bus_rd(ra(0, 2), 8'h11, "R5 data-in write ignored");
        chk({7'b0, irq}, 8'h00, "R3 irq lowered again");
        // R7 / R11 on channel 1
        host_wr(1, 8'h22, 1'b0);
        chk({7'b0, irq}, 8'h00, "R11 disabled channel leaves irq");
        bus_wr(ra(1, 0), 8'hFF);
        bus_rd(ra(1, 0), 8'hF6, "R7 status write masked");
        bus_wr(ra(1, 0), 8'h00);
        bus_rd(ra(1, 0), 8'h02, "R7 flags kept after clear");
        bus_rd(ra(2, 0), 8'h00, "R11 channel 2 untouched");
        bus_rd(ra(0, 0), 8'h00, "R11 channel 0 untouched");
        host_wr(2, 8'h9C, 1'b1);
        bus_rd(ra(1, 2), 8'h22, "R11 channel 1 keeps its byte");
        bus_rd(ra(2, 5), 8'h9C, "R11 channel 2 own byte");
        // R9: raise and lower in the same cycle, raise wins
        host_wr(1, 8'h23, 1'b0);
        bus_wr(ra(1, 6), 8'h01);
        @(negedge clk);
        host_chan = 2'd0; host_wdata = 8'h66; host_wr_data = 1'b1;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ra(1, 2);
        exp_q.push_back(8'h23); tag_q.push_back("R9 concurrent read byte");
        @(negedge clk);
        host_wr_data = 1'b0; bus_sel = 1'b0;
        chk({7'b0, irq}, 8'h01, "R9 raise wins over lower");
        bus_rd(ra(0, 2), 8'h66, "R9 byte behind raise");
        chk({7'b0, irq}, 8'h00, "R9 lower clears");
        // R10: idle cycle reads zero
        @(negedge clk);
        chk(bus_rdata, 8'h00, "R10 idle rdata zero");
        // R2: address map edges
        bus_wr(8'h0D, 8'hFF);
        bus_rd(ra(0, 0), 8'h00, "R2 odd write ignored");
        bus_rd(8'h0D, 8'h00, "R2 odd read zero");
        bus_rd(8'h0A, 8'h00, "R2 below range read zero");
        bus_rd(8'h42, 8'h00, "R2 end boundary read zero");
        bus_wr(8'h42, 8'hFF);
        bus_rd(ra(2, 8), 8'h00, "R2 last register after end write");
        bus_wr(ra(2, 6), 8'h5A);
        bus_rd(8'h3C, 8'h5A, "R2 channel 2 control at 0x3C");
        bus_rd(8'h1E, 8'h00, "R2 channel 1 base status");
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule